// File: doc/BRIEF.md
# Byte-Wide One-Time-Programmable Memory Model

This block is a synchronous, synthesizable stand-in for a 1024 x 8 one-time-programmable memory. A 10-bit address selects a word. Four chip selects gate the normal read path: two are active low and two are active high. A program-enable qualifier switches the block into its programming mode set. In that mode an active-low program pulse and an active-low verify strobe choose between program, verify, blank check and inhibit. Programming only ever sets bits: each write ORs the incoming byte into the stored word.

The tri-state data bus is modelled as an 8-bit data output plus an output-enable flag, with a separate 8-bit write-data input. Access times become cycle counts. After a select activation, or after an address change while the block is driving, data-valid rises a parameterised number of clock edges later. The output-enable flag falls a separate, shorter parameterised count of edges after the block stops driving. Driving the program or verify controls while the qualifier is inactive raises a mode-error flag and blocks the write.

Top module: `otp_byte_mem`

## Requirements
- R1: After reset every word holds 0x00, and oe_o, valid_o, mode_err_o and rdata_o are all 0.
- R2: With prog_en_i=0, prog_pulse_ni=1, verify_ni=1, sel1_ni=0, sel2_ni=0, sel3_i=1 and sel4_i=1, the block is in read mode and, once valid, rdata_o equals the word at addr_i.
- R3: If any one select is at its inactive level while prog_en_i=0, valid_o is 0 from the first edge that samples the deselect. oe_o falls at the HZ_CYC-th such edge.
- R4: With prog_en_i=1, sel1_ni=0, prog_pulse_ni=0 and verify_ni=1, every edge writes wdata_i into the word at addr_i, and oe_o stays 0. No write happens when prog_en_i=0.
- R5: A program ORs wdata_i into the stored word, so a bit once set is never cleared.
- R6: With prog_en_i=1, sel1_ni=0, verify_ni=0 and prog_pulse_ni=1, the block is in verify mode and drives the addressed word.
- R7: With prog_en_i=1 and either prog_pulse_ni=verify_ni=1 or sel1_ni=1, the block is in inhibit mode: no write happens and oe_o is 0.
- R8: With prog_en_i=1, sel1_ni=0 and both prog_pulse_ni and verify_ni low, the block runs a blank check and drives the addressed word. A never-programmed word reads 0x00.
- R9: When the block starts driving, oe_o is 1 after the first edge that samples the enabling inputs, and valid_o rises at the SEL_CYC-th such edge.
- R10: A change of addr_i while the block is driving clears valid_o until the ADDR_CYC-th edge that samples the new address.
- R11: With prog_en_i=0 and prog_pulse_ni=0 or verify_ni=0, mode_err_o is 1 after the sampling edge, no write happens, and the block does not drive.
- R12: rdata_o is 0x00 whenever valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 10 | Word address |
| sel1_ni | input | 1 | Select 1, active low; also gates programming modes |
| sel2_ni | input | 1 | Select 2, active low |
| sel3_i | input | 1 | Select 3, active high |
| sel4_i | input | 1 | Select 4, active high |
| prog_en_i | input | 1 | Program-mode qualifier |
| prog_pulse_ni | input | 1 | Program pulse, active low |
| verify_ni | input | 1 | Verify strobe, active low |
| wdata_i | input | 8 | Byte to program |
| rdata_o | output | 8 | Read data, zero when not valid |
| oe_o | output | 1 | Output enable (low means high impedance) |
| valid_o | output | 1 | Read data valid |
| mode_err_o | output | 1 | Program controls driven without the qualifier |

## Verification
Corrupt array state shows at the ports as soon as the affected word is read, verified or blank-checked. That is SEL_CYC edges after the block starts driving, or ADDR_CYC edges after a move to that address. A wrongly cleared or uncommitted bit shows up as a wrong rdata_o byte against a bench-side OR-accumulated copy of the array. A faulty delay counter shows as valid_o or oe_o toggling one edge early or late in the directed timing checks. A broken mode decode shows as a write that should have been blocked, found at the next verify of that word.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [2:0] {
    M_OFF,
    M_READ,
    M_PROG,
    M_VERIFY,
    M_BLANK,
    M_INHIBIT,
    M_ERR
  } otp_mode_e;
endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
  import otp_pkg::*;
(
  input  logic      sel1_ni,
  input  logic      sel2_ni,
  input  logic      sel3_i,
  input  logic      sel4_i,
  input  logic      prog_en_i,
  input  logic      prog_pulse_ni,
  input  logic      verify_ni,
  output otp_mode_e mode_o
);
  always_comb begin
    mode_o = M_OFF;
    if (prog_en_i) begin
      if (sel1_ni) mode_o = M_INHIBIT;
      else begin
        unique case ({prog_pulse_ni, verify_ni})
          2'b01:   mode_o = M_PROG;
          2'b10:   mode_o = M_VERIFY;
          2'b00:   mode_o = M_BLANK;
          default: mode_o = M_INHIBIT;
        endcase
      end
    end else if (!prog_pulse_ni || !verify_ni) begin
      mode_o = M_ERR;
    end else if (!sel1_ni && !sel2_ni && sel3_i && sel4_i) begin
      mode_o = M_READ;
    end
  end
endmodule

// File: rtl/otp_array.sv
module otp_array #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rword_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= mem_q[waddr_i] | wdata_i; // bits only ever set
    end
  end

  assign rword_o = mem_q[raddr_i];

  assert_or_merge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((mem_q[$past(waddr_i)] & $past(wdata_i)) == $past(wdata_i)));
endmodule

// File: rtl/otp_out_timing.sv
module otp_out_timing #(
  parameter int AW       = 10,
  parameter int ADDR_CYC = 4,
  parameter int SEL_CYC  = 2,
  parameter int HZ_CYC   = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o,
  output logic          valid_o,
  output logic          oe_o
);
  localparam int CW = $clog2(ADDR_CYC + 1);
  localparam int HW = $clog2(HZ_CYC + 1);

  logic          en_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] wait_q;
  logic [HW-1:0] hz_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      addr_q <= '0;
      wait_q <= '0;
      hz_q   <= '0;
    end else begin
      en_q   <= en_i;
      addr_q <= addr_i;
      if (en_i && !en_q)                wait_q <= CW'(SEL_CYC - 1);
      else if (en_i && addr_i != addr_q) wait_q <= CW'(ADDR_CYC - 1);
      else if (wait_q != '0)             wait_q <= wait_q - 1'b1;
      if (en_i)              hz_q <= HW'(HZ_CYC);
      else if (hz_q != '0)   hz_q <= hz_q - 1'b1;
    end
  end

  assign addr_o  = addr_q;
  assign valid_o = en_q && (wait_q == '0);
  assign oe_o    = (hz_q != '0);

  assert_valid_in_oe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> oe_o);
  assert_valid_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !valid_o);
  assert_oe_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> oe_o);
endmodule

// File: rtl/otp_byte_mem.sv
module otp_byte_mem
  import otp_pkg::*;
#(
  parameter int AW       = 10,
  parameter int DW       = 8,
  parameter int ADDR_CYC = 4,
  parameter int SEL_CYC  = 2,
  parameter int HZ_CYC   = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          sel1_ni,
  input  logic          sel2_ni,
  input  logic          sel3_i,
  input  logic          sel4_i,
  input  logic          prog_en_i,
  input  logic          prog_pulse_ni,
  input  logic          verify_ni,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          oe_o,
  output logic          valid_o,
  output logic          mode_err_o
);
  otp_mode_e     mode;
  logic          drive_en;
  logic          arr_we;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_word;
  logic          err_q;

  otp_mode_dec u_dec (
    .sel1_ni       (sel1_ni),
    .sel2_ni       (sel2_ni),
    .sel3_i        (sel3_i),
    .sel4_i        (sel4_i),
    .prog_en_i     (prog_en_i),
    .prog_pulse_ni (prog_pulse_ni),
    .verify_ni     (verify_ni),
    .mode_o        (mode)
  );

  assign drive_en = (mode == M_READ) || (mode == M_VERIFY) || (mode == M_BLANK);
  assign arr_we   = (mode == M_PROG);

  otp_array #(.AW(AW), .DW(DW)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (arr_we),
    .waddr_i (addr_i),
    .wdata_i (wdata_i),
    .raddr_i (rd_addr),
    .rword_o (rd_word)
  );

  otp_out_timing #(
    .AW(AW), .ADDR_CYC(ADDR_CYC), .SEL_CYC(SEL_CYC), .HZ_CYC(HZ_CYC)
  ) u_timing (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (drive_en),
    .addr_i  (addr_i),
    .addr_o  (rd_addr),
    .valid_o (valid_o),
    .oe_o    (oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= (mode == M_ERR);
  end

  assign mode_err_o = err_q;
  assign rdata_o    = valid_o ? rd_word : '0;

  assert_no_write_unqualified_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_en_i |-> !arr_we);
  assert_err_no_drive_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_err_o |-> !valid_o);
endmodule

// File: tb/otp_byte_mem_tb.sv
module otp_byte_mem_tb;
  localparam int AW = 10, DW = 8, ADDR_CYC = 4, SEL_CYC = 2, HZ_CYC = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [AW-1:0] addr;
  logic s1n, s2n, s3, s4, pe, ppn, vn;
  logic [DW-1:0] wd, rdata;
  logic oe, valid, err;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] model [1 << AW];

  always #2 clk = ~clk;

  otp_byte_mem #(.AW(AW), .DW(DW), .ADDR_CYC(ADDR_CYC), .SEL_CYC(SEL_CYC), .HZ_CYC(HZ_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .sel1_ni(s1n), .sel2_ni(s2n),
    .sel3_i(s3), .sel4_i(s4), .prog_en_i(pe), .prog_pulse_ni(ppn), .verify_ni(vn),
    .wdata_i(wd), .rdata_o(rdata), .oe_o(oe), .valid_o(valid), .mode_err_o(err));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic p, input logic pp, input logic v, input logic [3:0] sel,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    pe = p; ppn = pp; vn = v; {s1n, s2n, s3, s4} = sel; addr = a; wd = d;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  localparam logic [3:0] SEL_ON = 4'b0011;

  task automatic idle(input logic [AW-1:0] a);
    drive(1'b0, 1'b1, 1'b1, 4'b1100, a, 8'h00);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [DW-1:0] d);
    drive(1'b1, 1'b0, 1'b1, SEL_ON, a, d);
    edges(1);
    model[a] = model[a] | d;
    idle(a);
    edges(HZ_CYC);
  endtask

  function automatic logic [DW-1:0] exp_word(input logic [AW-1:0] a);
    return model[a];
  endfunction

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < (1 << AW); i++) model[i] = '0;
    idle('0);
    edges(2);
    chk("R1", "oe", oe, 0);
    chk("R1", "valid", valid, 0);
    chk("R1", "err", err, 0);
    chk("R1", "rdata", rdata, 0);
    rst_ni = 1'b1;
    edges(1);

    // blank check on untouched word
    drive(1'b1, 1'b0, 1'b0, SEL_ON, 10'd5, 8'h00);
    edges(SEL_CYC);
    chk("R8", "blank valid", valid, 1);
    chk("R8", "blank data", rdata, 0);
    idle(10'd5); edges(HZ_CYC);

    // program then OR-merge
    prog(10'd5, 8'hA5);
    drive(1'b1, 1'b1, 1'b0, SEL_ON, 10'd5, 8'h00);
    edges(SEL_CYC);
    chk("R6", "verify data", rdata, 8'hA5);
    idle(10'd5); edges(HZ_CYC);
    prog(10'd5, 8'h0F);
    prog(10'd5, 8'h00);
    drive(1'b1, 1'b1, 1'b0, SEL_ON, 10'd5, 8'h00);
    edges(SEL_CYC);
    chk("R5", "or merge", rdata, 8'hAF);
    idle(10'd5); edges(HZ_CYC);

    // oe low during program
    drive(1'b1, 1'b0, 1'b1, SEL_ON, 10'd9, 8'h01);
    edges(1);
    model[9] = model[9] | 8'h01;
    chk("R4", "oe in program", oe, 0);
    idle(10'd9); edges(HZ_CYC);

    // read select timing
    drive(1'b0, 1'b1, 1'b1, SEL_ON, 10'd5, 8'h00);
    edges(1);
    chk("R9", "oe after first edge", oe, 1);
    chk("R12", "rdata while not valid", rdata, 0);
    if (SEL_CYC > 1) begin
      edges(SEL_CYC - 2);
      chk("R9", "valid one edge early", valid, 0);
      edges(1);
    end
    chk("R9", "valid at SEL_CYC", valid, 1);
    chk("R2", "read data", rdata, 8'hAF);

    // address change
    addr = 10'd6;
    edges(ADDR_CYC - 1);
    chk("R10", "valid before ADDR_CYC", valid, 0);
    edges(1);
    chk("R10", "valid at ADDR_CYC", valid, 1);
    chk("R10", "new word", rdata, 0);

    // each select alone deselects
    for (int k = 0; k < 4; k++) begin
      logic [3:0] bad;
      bad = SEL_ON ^ (4'b1000 >> k);
      drive(1'b0, 1'b1, 1'b1, SEL_ON, 10'd5, 8'h00);
      edges(ADDR_CYC);
      chk("R2", "reselect data", rdata, 8'hAF);
      drive(1'b0, 1'b1, 1'b1, bad, 10'd5, 8'h00);
      edges(1);
      chk("R3", "valid after deselect", valid, 0);
      chk("R3", "oe held", oe, (HZ_CYC > 1) ? 1 : 0);
      edges(HZ_CYC - 1);
      chk("R3", "oe at HZ_CYC", oe, 0);
    end

    // inhibit: both strobes high
    drive(1'b1, 1'b1, 1'b1, SEL_ON, 10'd7, 8'hFF);
    edges(3);
    chk("R7", "oe inhibit", oe, 0);
    // inhibit: sel1 high with program pulse low
    drive(1'b1, 1'b0, 1'b1, 4'b1011, 10'd7, 8'hFF);
    edges(3);
    chk("R7", "oe sel1 inhibit", oe, 0);
    drive(1'b1, 1'b1, 1'b0, SEL_ON, 10'd7, 8'h00);
    edges(SEL_CYC);
    chk("R7", "no write", rdata, 0);
    idle(10'd7); edges(HZ_CYC);

    // mode error
    drive(1'b0, 1'b0, 1'b1, SEL_ON, 10'd8, 8'hFF);
    edges(1);
    chk("R11", "err prog", err, 1);
    chk("R11", "no drive", oe, 0);
    drive(1'b0, 1'b1, 1'b0, SEL_ON, 10'd8, 8'hFF);
    edges(1);
    chk("R11", "err verify", err, 1);
    chk("R11", "no valid", valid, 0);
    drive(1'b1, 1'b1, 1'b0, SEL_ON, 10'd8, 8'h00);
    edges(1);
    chk("R11", "err cleared", err, 0);
    edges(SEL_CYC - 1);
    chk("R11", "no write", rdata, 0);

    // constrained random
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      logic [3:0] bs;
      op = int'($urandom_range(0, 6));
      a  = AW'($urandom_range(0, 31));
      d  = DW'($urandom);
      bs = 4'($urandom);
      if (bs == SEL_ON) bs = 4'b1111;
      case (op)
        0: drive(1'b0, 1'b1, 1'b1, SEL_ON, a, d);
        1: drive(1'b1, 1'b0, 1'b1, SEL_ON, a, d & DW'($urandom));
        2: drive(1'b1, 1'b1, 1'b0, SEL_ON, a, d);
        3: drive(1'b1, 1'b0, 1'b0, SEL_ON, a, d);
        4: drive(1'b1, 1'b1, 1'b1, bs, a, d);
        5: drive(1'b0, 1'b1, 1'b1, bs, a, d);
        default: drive(1'b0, 1'($urandom), 1'b0, bs, a, d);
      endcase
      if (op == 1) model[a] = model[a] | wd;
      edges(ADDR_CYC);
      if (op == 0 || op == 2 || op == 3) begin
        chk("R2", "rand valid", valid, 1);
        chk("R6", "rand data", rdata, exp_word(a));
      end else begin
        chk("R12", "rand rdata idle", rdata, 0);
        chk("R7", "rand oe", oe, 0);
      end
      chk("R11", "rand err", err, (op == 6) ? 1 : 0);
    end

    // full sweep of a few programmed words
    for (int a = 0; a < 32; a++) begin
      drive(1'b0, 1'b1, 1'b1, SEL_ON, AW'(a), 8'h00);
      edges(ADDR_CYC);
      chk("R5", "final sweep", rdata, exp_word(AW'(a)));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule